// File: doc/BRIEF.md
# Fetch Buffer with In-Order Issue Steering

This block sits between instruction fetch and the scheduling queues of an out-of-order core. Each cycle the fetch side may offer a group of one to eight instructions. The group is written into a twelve-entry circular buffer only if the whole group fits in the space that is free at the start of the cycle. From the oldest end of the buffer, up to four instructions leave each cycle in program order. Each one is steered to one of three downstream queues by a two-bit class tag that travels with it. The queues are a narrow integer queue, a wide integer queue and a floating-point queue.

Each downstream queue reports how many free entries it has. The narrow integer queue takes at most one instruction per cycle. The wide integer and floating-point queues each take up to four. Issue walks the four oldest entries in order and stops at the first one whose queue has no room left in this cycle; no younger instruction passes it. A flush input empties the buffer in one cycle. Decoding is reduced to the class tag, and the queues themselves are outside the block.

Top module: `fetch_issue_steer`

## Requirements
- R1: After reset the buffer is empty, no issue lane is active, and a fetch group of any size from 1 to 8 is offered fetch_ready.
- R2: fetch_ready is high only when flush is low, fetch_count is between 1 and 8, and fetch_count is at most 12 minus the buffer occupancy at the start of the cycle. A group is never partly accepted.
- R3: Instructions leave the buffer in the order they were fetched. Issue lane 0 always carries the oldest buffered instruction, and the lanes that follow carry the next oldest in turn.
- R4: At most four instructions issue per cycle. The active lanes always form a contiguous run starting at lane 0.
- R5: The class tag is bits [17:16] of each 18-bit fetch lane, and the payload is bits [15:0]. Code 0 steers to the narrow integer queue (iss_to_nar), codes 1 and 3 steer to the wide integer queue (iss_to_wide), and code 2 steers to the floating-point queue (iss_to_fp). Each issued lane is set in exactly one mask.
- R6: At most one instruction goes to the narrow integer queue per cycle, and none goes there when nar_free is 0.
- R7: The wide integer queue and the floating-point queue each receive at most min(4, free count) instructions per cycle.
- R8: Issue stops at the first instruction whose queue cannot take it this cycle. That instruction and every younger one stay in the buffer for a later cycle.
- R9: While flush is high, nothing issues and no fetch group is accepted. On the next cycle the buffer is empty.
- R10: An instruction accepted in a cycle can first issue in the following cycle. Accepting a group and issuing older entries may happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the buffer and blocks issue and fetch this cycle |
| fetch_valid | input | 1 | A fetch group is offered |
| fetch_count | input | 4 | Number of instructions in the group (1 to 8) |
| fetch_data | input | 144 | Eight 18-bit lanes, lane k at bits [18k+17:18k], class tag in the top two bits |
| fetch_ready | output | 1 | The offered group fits and is taken when fetch_valid is high |
| nar_free | input | 4 | Free entries in the narrow integer queue |
| wide_free | input | 4 | Free entries in the wide integer queue |
| fp_free | input | 4 | Free entries in the floating-point queue |
| iss_data | output | 64 | Four 16-bit issue lanes, lane i at bits [16i+15:16i] |
| iss_to_nar | output | 4 | Per-lane push into the narrow integer queue |
| iss_to_wide | output | 4 | Per-lane push into the wide integer queue |
| iss_to_fp | output | 4 | Per-lane push into the floating-point queue |

## Verification
The bench targets issue windows that are cut short: two narrow instructions back to back, a narrow instruction at the head while nar_free is zero, and a run of floating-point instructions larger than fp_free. A design that skips a blocked instruction would issue younger instructions out of order. A design that ignores the per-queue limit would set more mask bits than the queue can take. The bench also fills the buffer to exactly twelve entries and offers groups one entry too large, where an off-by-one in the space check either refuses a fitting group or overwrites live entries. It checks that a group written into an empty buffer does not issue in the same cycle, that code 3 lands in the wide queue, and that a flush during heavy traffic leaves nothing behind. Along with these cases, a long randomised phase with wrap-around of the circular store is checked against the reference queue every cycle.

// File: rtl/fbis_pkg.sv
package fbis_pkg;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_NARROW   = 2'd0,
    CLS_WIDE     = 2'd1,
    CLS_FP       = 2'd2,
    CLS_WIDE_ALT = 2'd3
  } iclass_e;
endpackage

// File: rtl/fbis_store.sv
module fbis_store #(
  parameter int DEPTH   = 12,
  parameter int FETCH_W = 8,
  parameter int ISSUE_W = 4,
  parameter int ENT_W   = 18,
  parameter int OCC_W   = 4,
  parameter int FCNT_W  = 4,
  parameter int ICNT_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic [FCNT_W-1:0]          wr_cnt,
  input  logic [FETCH_W*ENT_W-1:0]   wr_data,
  input  logic [ICNT_W-1:0]          rd_cnt,
  output logic [ISSUE_W*ENT_W-1:0]   rd_data,
  output logic [OCC_W-1:0]           occ
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [ENT_W-1:0] mem_q  [DEPTH];
  logic [ENT_W-1:0] mem_d  [DEPTH];
  logic [DEPTH-1:0] mem_we;
  logic [PTR_W-1:0] head_q, head_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             ptr_en;

  function automatic logic [PTR_W-1:0] wrap(input int v);
    return PTR_W'(v % DEPTH);
  endfunction

  // read window: the ISSUE_W oldest slots
  for (genvar r = 0; r < ISSUE_W; r++) begin : g_rd
    assign rd_data[r*ENT_W +: ENT_W] = mem_q[wrap(int'(head_q) + r)];
  end

  // write steering: group lane k lands behind the current tail
  always_comb begin
    mem_we = '0;
    for (int e = 0; e < DEPTH; e++) mem_d[e] = mem_q[e];
    for (int k = 0; k < FETCH_W; k++) begin
      if (k < int'(wr_cnt)) begin
        mem_we[wrap(int'(head_q) + int'(occ_q) + k)] = 1'b1;
        mem_d[wrap(int'(head_q) + int'(occ_q) + k)]  = wr_data[k*ENT_W +: ENT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (mem_we[e]) mem_q[e] <= mem_d[e];
    end
  end

  // pointer next state
  always_comb begin
    if (flush) begin
      head_d = '0;
      occ_d  = '0;
    end else begin
      head_d = wrap(int'(head_q) + int'(rd_cnt));
      occ_d  = OCC_W'(int'(occ_q) - int'(rd_cnt) + int'(wr_cnt));
    end
    ptr_en = flush | (|rd_cnt) | (|wr_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      occ_q  <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      occ_q  <= occ_d;
    end
  end

  assign occ = occ_q;
endmodule

// File: rtl/fbis_steer.sv
module fbis_steer
  import fbis_pkg::*;
#(
  parameter int ISSUE_W  = 4,
  parameter int ENT_W    = 18,
  parameter int OCC_W    = 4,
  parameter int CRD_W    = 4,
  parameter int ICNT_W   = 3,
  parameter int NAR_MAX  = 1,
  parameter int WIDE_MAX = 4,
  parameter int FP_MAX   = 4
) (
  input  logic                     hold,
  input  logic [OCC_W-1:0]         occ,
  input  logic [ISSUE_W*ENT_W-1:0] lane_data,
  input  logic [CRD_W-1:0]         nar_free,
  input  logic [CRD_W-1:0]         wide_free,
  input  logic [CRD_W-1:0]         fp_free,
  output logic [ISSUE_W-1:0]       to_nar,
  output logic [ISSUE_W-1:0]       to_wide,
  output logic [ISSUE_W-1:0]       to_fp,
  output logic [ICNT_W-1:0]        iss_cnt
);
  int      lim_n, lim_w, lim_f;
  int      used_n, used_w, used_f, taken;
  logic    blocked, fits;
  iclass_e cls;

  always_comb begin
    lim_n   = (int'(nar_free)  < NAR_MAX)  ? int'(nar_free)  : NAR_MAX;
    lim_w   = (int'(wide_free) < WIDE_MAX) ? int'(wide_free) : WIDE_MAX;
    lim_f   = (int'(fp_free)   < FP_MAX)   ? int'(fp_free)   : FP_MAX;
    used_n  = 0;
    used_w  = 0;
    used_f  = 0;
    taken   = 0;
    blocked = hold;
    to_nar  = '0;
    to_wide = '0;
    to_fp   = '0;
    for (int i = 0; i < ISSUE_W; i++) begin
      cls = iclass_e'(lane_data[i*ENT_W + ENT_W - 1 -: CLS_W]);
      unique case (cls)
        CLS_NARROW: fits = used_n < lim_n;
        CLS_FP:     fits = used_f < lim_f;
        default:    fits = used_w < lim_w;
      endcase
      if (i >= int'(occ) || !fits) blocked = 1'b1;
      if (!blocked) begin
        taken = taken + 1;
        unique case (cls)
          CLS_NARROW: begin to_nar[i]  = 1'b1; used_n = used_n + 1; end
          CLS_FP:     begin to_fp[i]   = 1'b1; used_f = used_f + 1; end
          default:    begin to_wide[i] = 1'b1; used_w = used_w + 1; end
        endcase
      end
    end
    iss_cnt = ICNT_W'(taken);
  end
endmodule

// File: rtl/fetch_issue_steer.sv
module fetch_issue_steer
  import fbis_pkg::*;
#(
  parameter int DEPTH    = 12,
  parameter int FETCH_W  = 8,
  parameter int ISSUE_W  = 4,
  parameter int DATA_W   = 16,
  parameter int CRD_W    = 4,
  parameter int NAR_MAX  = 1,
  parameter int WIDE_MAX = 4,
  parameter int FP_MAX   = 4,
  localparam int ENT_W   = DATA_W + CLS_W,
  localparam int OCC_W   = $clog2(DEPTH + 1),
  localparam int FCNT_W  = $clog2(FETCH_W + 1),
  localparam int ICNT_W  = $clog2(ISSUE_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      fetch_valid,
  input  logic [FCNT_W-1:0]         fetch_count,
  input  logic [FETCH_W*ENT_W-1:0]  fetch_data,
  output logic                      fetch_ready,
  input  logic [CRD_W-1:0]          nar_free,
  input  logic [CRD_W-1:0]          wide_free,
  input  logic [CRD_W-1:0]          fp_free,
  output logic [ISSUE_W*DATA_W-1:0] iss_data,
  output logic [ISSUE_W-1:0]        iss_to_nar,
  output logic [ISSUE_W-1:0]        iss_to_wide,
  output logic [ISSUE_W-1:0]        iss_to_fp
);
  logic [OCC_W-1:0]         occ;
  logic [FCNT_W-1:0]        wr_cnt;
  logic [ICNT_W-1:0]        rd_cnt;
  logic [ISSUE_W*ENT_W-1:0] rd_data;
  logic                     grp_fits;

  // whole-group admission against start-of-cycle space
  always_comb begin
    grp_fits    = (int'(fetch_count) >= 1) && (int'(fetch_count) <= FETCH_W) &&
                  (int'(fetch_count) <= DEPTH - int'(occ));
    fetch_ready = !flush && grp_fits;
    wr_cnt      = (fetch_valid && fetch_ready) ? fetch_count : '0;
  end

  fbis_store #(
    .DEPTH(DEPTH), .FETCH_W(FETCH_W), .ISSUE_W(ISSUE_W), .ENT_W(ENT_W),
    .OCC_W(OCC_W), .FCNT_W(FCNT_W), .ICNT_W(ICNT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_cnt(wr_cnt), .wr_data(fetch_data),
    .rd_cnt(rd_cnt), .rd_data(rd_data), .occ(occ)
  );

  fbis_steer #(
    .ISSUE_W(ISSUE_W), .ENT_W(ENT_W), .OCC_W(OCC_W), .CRD_W(CRD_W),
    .ICNT_W(ICNT_W), .NAR_MAX(NAR_MAX), .WIDE_MAX(WIDE_MAX), .FP_MAX(FP_MAX)
  ) u_steer (
    .hold(flush), .occ(occ), .lane_data(rd_data),
    .nar_free(nar_free), .wide_free(wide_free), .fp_free(fp_free),
    .to_nar(iss_to_nar), .to_wide(iss_to_wide), .to_fp(iss_to_fp),
    .iss_cnt(rd_cnt)
  );

  for (genvar i = 0; i < ISSUE_W; i++) begin : g_out
    assign iss_data[i*DATA_W +: DATA_W] = rd_data[i*ENT_W +: DATA_W];
  end
endmodule

// File: rtl/fetch_issue_steer_chk.sv
module fetch_issue_steer_chk #(
  parameter int DEPTH    = 12,
  parameter int ISSUE_W  = 4,
  parameter int CRD_W    = 4,
  parameter int OCC_W    = 4,
  parameter int FCNT_W   = 4,
  parameter int NAR_MAX  = 1,
  parameter int WIDE_MAX = 4,
  parameter int FP_MAX   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               fetch_ready,
  input logic [CRD_W-1:0]   nar_free,
  input logic [CRD_W-1:0]   wide_free,
  input logic [CRD_W-1:0]   fp_free,
  input logic [ISSUE_W-1:0] iss_to_nar,
  input logic [ISSUE_W-1:0] iss_to_wide,
  input logic [ISSUE_W-1:0] iss_to_fp,
  input logic [OCC_W-1:0]   occ,
  input logic [FCNT_W-1:0]  wr_cnt
);
  logic [ISSUE_W-1:0] iss_any;
  assign iss_any = iss_to_nar | iss_to_wide | iss_to_fp;

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (iss_any == '0 && !fetch_ready));
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0);
  // R2
  capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);
  // R6
  nar_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_to_nar) <= NAR_MAX && $countones(iss_to_nar) <= int'(nar_free));
  // R7
  wide_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_to_wide) <= WIDE_MAX && $countones(iss_to_wide) <= int'(wide_free));
  // R7
  fp_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_to_fp) <= FP_MAX && $countones(iss_to_fp) <= int'(fp_free));
  // R4
  lane_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(iss_any ^ (iss_any >> 1)));
  // R5
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_to_nar & iss_to_wide) | (iss_to_nar & iss_to_fp) | (iss_to_wide & iss_to_fp)) == '0);
  // R3
  occ_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(occ) == int'($past(occ)) - $countones($past(iss_any)) + int'($past(wr_cnt)));
  // R10
  no_issue_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> iss_any == '0);
endmodule

bind fetch_issue_steer fetch_issue_steer_chk #(
  .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .CRD_W(CRD_W), .OCC_W(OCC_W),
  .FCNT_W(FCNT_W), .NAR_MAX(NAR_MAX), .WIDE_MAX(WIDE_MAX), .FP_MAX(FP_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_ready(fetch_ready),
  .nar_free(nar_free), .wide_free(wide_free), .fp_free(fp_free),
  .iss_to_nar(iss_to_nar), .iss_to_wide(iss_to_wide), .iss_to_fp(iss_to_fp),
  .occ(occ), .wr_cnt(wr_cnt)
);

// File: tb/fetch_issue_steer_tb.sv
`timescale 1ns/1ps
module fetch_issue_steer_tb;
  localparam int DEPTH = 12, FW = 8, IW = 4, DW = 16, EW = 18;

  logic          clk, rst_n, flush, fetch_valid, fetch_ready;
  logic [3:0]    fetch_count, nar_free, wide_free, fp_free;
  logic [FW*EW-1:0] fetch_data;
  logic [IW*DW-1:0] iss_data;
  logic [IW-1:0] iss_to_nar, iss_to_wide, iss_to_fp;

  fetch_issue_steer u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
    .fetch_count(fetch_count), .fetch_data(fetch_data), .fetch_ready(fetch_ready),
    .nar_free(nar_free), .wide_free(wide_free), .fp_free(fp_free),
    .iss_data(iss_data), .iss_to_nar(iss_to_nar), .iss_to_wide(iss_to_wide),
    .iss_to_fp(iss_to_fp)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct { int data; int cls; } ent_t;
  ent_t model[$];

  int  checks = 0, errors = 0;
  bit  done = 0;
  int  tag = 1;
  // staged stimulus
  bit  s_valid, s_flush;
  int  s_cnt, s_nf, s_wf, s_ff;
  int  s_cls[FW];
  // expectations and observed values of the last step
  bit  e_ready;
  int  e_n;
  logic [IW-1:0] e_nar, e_wide, e_fp;
  int  d_n;
  bit  d_ready;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic calc();
    int ln, lw, lf, un, uw, uf, c;
    bit stop;
    ln = s_nf < 1 ? s_nf : 1;
    lw = s_wf < 4 ? s_wf : 4;
    lf = s_ff < 4 ? s_ff : 4;
    un = 0; uw = 0; uf = 0; e_n = 0; stop = s_flush;
    e_nar = '0; e_wide = '0; e_fp = '0;
    e_ready = !s_flush && s_cnt >= 1 && s_cnt <= FW && s_cnt <= DEPTH - model.size();
    for (int i = 0; i < IW; i++) begin
      if (i >= model.size()) stop = 1;
      if (!stop) begin
        c = model[i].cls;
        if (c == 0) begin
          if (un < ln) begin un++; e_nar[i] = 1; end else stop = 1;
        end else if (c == 2) begin
          if (uf < lf) begin uf++; e_fp[i] = 1; end else stop = 1;
        end else begin
          if (uw < lw) begin uw++; e_wide[i] = 1; end else stop = 1;
        end
        if (!stop) e_n++;
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    fetch_valid = s_valid;
    fetch_count = 4'(s_cnt);
    flush       = s_flush;
    nar_free    = 4'(s_nf);
    wide_free   = 4'(s_wf);
    fp_free     = 4'(s_ff);
    for (int k = 0; k < FW; k++)
      fetch_data[k*EW +: EW] = {2'(s_cls[k]), 16'(tag + k)};
    #2;
    calc();
    d_ready = fetch_ready;
    d_n     = $countones(iss_to_nar | iss_to_wide | iss_to_fp);
    chk(fetch_ready == e_ready, "R2", "fetch_ready", int'(fetch_ready), int'(e_ready));
    chk(iss_to_nar == e_nar, "R6", "narrow mask", int'(iss_to_nar), int'(e_nar));
    chk(iss_to_wide == e_wide, "R5", "wide mask", int'(iss_to_wide), int'(e_wide));
    chk(iss_to_fp == e_fp, "R7", "fp mask", int'(iss_to_fp), int'(e_fp));
    for (int i = 0; i < e_n; i++)
      chk(int'(iss_data[i*DW +: DW]) == model[i].data, "R3", "lane payload",
          int'(iss_data[i*DW +: DW]), model[i].data);
    @(posedge clk);
    if (s_flush) model.delete();
    else begin
      for (int i = 0; i < e_n; i++) void'(model.pop_front());
      if (s_valid && e_ready) begin
        for (int k = 0; k < s_cnt; k++) begin
          ent_t en;
          en.data = (tag + k) & 16'hFFFF;
          en.cls  = s_cls[k];
          model.push_back(en);
        end
        tag = (tag + s_cnt) & 16'hFFFF;
      end
    end
  endtask

  task automatic set(bit v, int cnt, int nf, int wf, int ff, bit fl);
    s_valid = v; s_cnt = cnt; s_nf = nf; s_wf = wf; s_ff = ff; s_flush = fl;
  endtask

  task automatic classes(int c);
    for (int k = 0; k < FW; k++) s_cls[k] = c;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; fetch_valid = 1'b0; fetch_count = '0;
    fetch_data = '0; nar_free = '0; wide_free = '0; fp_free = '0;
    classes(1);
    set(0, 8, 4, 4, 4, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset, full group offered
    step();
    chk(d_ready == 1, "R1", "ready after reset", int'(d_ready), 1);
    chk(d_n == 0, "R1", "no issue after reset", d_n, 0);

    // R10: group written into empty buffer does not issue that cycle
    classes(1); set(1, 4, 4, 4, 4, 0); step();
    chk(d_n == 0, "R10", "issue in fill cycle", d_n, 0);
    // R4: four wide issue next cycle, lanes 0..3
    set(0, 1, 4, 4, 4, 0); step();
    chk(d_n == 4 && iss_to_wide == 4'b1111, "R4", "four issued", d_n, 4);

    // R2: fill to capacity with issue stalled
    set(1, 8, 0, 0, 0, 0); step();
    set(1, 8, 0, 0, 0, 0); step();
    chk(d_ready == 0, "R2", "oversized group refused", int'(d_ready), 0);
    set(1, 4, 0, 0, 0, 0); step();
    chk(d_ready == 1, "R2", "exact fit accepted", int'(d_ready), 1);
    set(1, 1, 0, 0, 0, 0); step();
    chk(d_ready == 0, "R2", "full buffer refuses one", int'(d_ready), 0);

    // R9: flush blocks issue and fetch, empties buffer
    set(1, 1, 4, 4, 4, 1); step();
    chk(d_n == 0 && d_ready == 0, "R9", "flush cycle quiet", d_n, 0);
    set(0, 1, 4, 4, 4, 0); step();
    chk(d_n == 0, "R9", "empty after flush", d_n, 0);

    // R8: narrow, narrow, wide, fp -> only first issues
    s_cls[0] = 0; s_cls[1] = 0; s_cls[2] = 1; s_cls[3] = 2;
    set(1, 4, 4, 4, 4, 0); step();
    set(0, 1, 4, 4, 4, 0); step();
    chk(d_n == 1 && iss_to_nar == 4'b0001, "R8", "second narrow blocks", d_n, 1);
    step();
    chk(d_n == 3, "R8", "remaining three issue", d_n, 3);

    // R6: narrow at head with no narrow credit blocks wide behind it
    s_cls[0] = 0; s_cls[1] = 1; s_cls[2] = 1;
    set(1, 3, 0, 4, 4, 0); step();
    set(0, 1, 0, 4, 4, 0); step();
    chk(d_n == 0, "R6", "narrow without credit", d_n, 0);
    set(0, 1, 1, 4, 4, 0); step();
    chk(d_n == 3, "R6", "narrow with credit", d_n, 3);

    // R7: four fp with two credits
    classes(2); set(1, 4, 4, 4, 2, 0); step();
    set(0, 1, 4, 4, 2, 0); step();
    chk(d_n == 2 && iss_to_fp == 4'b0011, "R7", "fp limited by credit", d_n, 2);
    set(0, 1, 4, 4, 4, 0); step();

    // R5: code 3 steers to wide queue
    classes(3); set(1, 2, 4, 4, 4, 0); step();
    set(0, 1, 4, 4, 4, 0); step();
    chk(iss_to_wide == 4'b0011 && iss_to_nar == 0 && iss_to_fp == 0, "R5",
        "code 3 to wide", int'(iss_to_wide), 3);

    // randomised traffic with wrap-around and occasional flush
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int k = 0; k < FW; k++) s_cls[k] = int'($urandom_range(0, 3));
      set(($urandom_range(0, 3) != 0), int'($urandom_range(0, 9)),
          int'($urandom_range(0, 2)), int'($urandom_range(0, 6)),
          int'($urandom_range(0, 6)), ($urandom_range(0, 63) == 0));
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule